// File: doc/BRIEF.md
# Edge-Restarted Pulse Interval Timer

This block measures the time between transitions on a receive line. The raw line is first passed through a two-flop synchronizer. A transition detector then watches the synchronized level and picks out the transitions that a two-bit polarity control selects. Each selected transition restarts a saturating cycle counter. At the same moment, the block captures the count reached so far and compares it with a nominal bit period. The tolerance window around that period is asymmetric and is chosen by a second two-bit control.

The block presents three results. It gives the last captured interval and a flag that says whether that interval fell inside the window. It also gives a one-cycle strobe that marks each capture. A downstream bit decoder uses the strobe, interval and flag to tell valid pulse spacings from noise. Clearing the receive enable parks the timer at zero and silences it.

Top module: `edge_interval_timer`

## Requirements
- R1: During and straight after reset, `interval_o`, `in_window_o` and `edge_stb_o` are all zero.
- R2: `line_i` passes through two synchronizer flops and an edge register. A transition driven before clock edge k gives `edge_stb_o` high in the cycle after edge k+2, and not before.
- R3: With `edge_mode_i` = 2'b00, no transition restarts the timer and `edge_stb_o` stays low.
- R4: With `edge_mode_i` = 2'b01, only high-to-low transitions of the synchronized line restart the timer.
- R5: With `edge_mode_i` = 2'b10, only low-to-high transitions restart the timer.
- R6: With `edge_mode_i` = 2'b11, transitions of either direction restart the timer.
- R7: On a restart, `interval_o` takes the number of clock cycles since the previous restart, or since enable if there was none. The counter reloads to 1 and `edge_stb_o` is high for that one cycle.
- R8: On a restart, `in_window_o` is set exactly when nominal − L ≤ captured ≤ nominal + U. L is 4 when `win_mode_i[0]`=1 and 3 otherwise. U is 4 when `win_mode_i[1]`=1 and 3 otherwise. So 00 gives +3/−3, 01 gives +3/−4, 10 gives +4/−3 and 11 gives +4/−4.
- R9: The counter saturates at 2^CNT_W−1 and never wraps. A restart after a long idle period captures that maximum value.
- R10: While `rx_en_i` is low, the counter is held at zero and no strobe is produced. After enable, counting starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable |
| line_i | input | 1 | Raw, unsynchronized receive line |
| edge_mode_i | input | 2 | Restart polarity: 00 off, 01 falling, 10 rising, 11 both |
| win_mode_i | input | 2 | Window limits: bit1 widens the upper limit, bit0 widens the lower limit |
| nominal_i | input | CNT_W | Nominal interval in clock cycles |
| interval_o | output | CNT_W | Last captured interval |
| in_window_o | output | 1 | Last captured interval was inside the window |
| edge_stb_o | output | 1 | One-cycle strobe on each capture |

## Verification
The assertions check four things on every cycle. No strobe follows a disabled cycle or a cycle with polarity off. The counter is zero after a disabled cycle and stays at its maximum once there. Every strobe comes with the counter reloaded to one. A set window flag is also checked to stay within the widest possible limits. Other behaviours need the bench's scenarios and its behavioural model, compared on every clock: the exact synchronizer latency, polarity selection for each mode, the window boundaries for all four limit codes, and the captured value after saturation.

// File: rtl/eit_pkg.sv
package eit_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Base tolerance; each window-mode bit widens one side by one count.
    localparam int unsigned WIN_BASE = 3;

endpackage

// File: rtl/eit_sync.sv
module eit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.chain[0] = async_i;
            end
        end else begin : g_multi
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/eit_edge_pick.sv
module eit_edge_pick
    import eit_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      en_i,
    input  logic      level_i,
    input  edge_sel_e mode_i,
    output logic      restart_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic rise, fall, pick;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise      = level_i & ~st_q.prev;
        fall      = ~level_i & st_q.prev;
        unique case (mode_i)
            EDGE_OFF:  pick = 1'b0;
            EDGE_FALL: pick = fall;
            EDGE_RISE: pick = rise;
            EDGE_BOTH: pick = rise | fall;
            default:   pick = 1'b0;
        endcase
        restart_o = en_i & pick;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5: a rising-only restart needs the synchronized level to be high
    a_r5_rise_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart_o && mode_i == EDGE_RISE) |-> level_i);

endmodule

// File: rtl/eit_window.sv
module eit_window
    import eit_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] nominal_i,
    input  logic [1:0]       mode_i,
    output logic             hit_o
);
    localparam int unsigned XW = CNT_W + 1;
    localparam logic [XW-1:0] BASE_X = XW'(WIN_BASE);

    logic [XW-1:0] cnt_x, nom_x, lo_x, hi_x;

    always_comb begin
        cnt_x = {1'b0, count_i};
        nom_x = {1'b0, nominal_i};
        lo_x  = BASE_X + {{CNT_W{1'b0}}, mode_i[0]};
        hi_x  = BASE_X + {{CNT_W{1'b0}}, mode_i[1]};
        // nominal - lo <= count  rewritten as  count + lo >= nominal
        hit_o = ((cnt_x + lo_x) >= nom_x) && (cnt_x <= (nom_x + hi_x));
    end

endmodule

// File: rtl/eit_interval_cnt.sv
module eit_interval_cnt #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic             win_hit_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] interval_o,
    output logic             in_window_o,
    output logic             stb_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] iv;
        logic             win;
        logic             stb;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (restart_i) begin
            st_d.iv  = st_q.cnt;
            st_d.win = win_hit_i;
            st_d.cnt = CNT_ONE;
            st_d.stb = 1'b1;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o     = st_q.cnt;
    assign interval_o  = st_q.iv;
    assign in_window_o = st_q.win;
    assign stb_o       = st_q.stb;

    // R10: a disabled cycle leaves the counter at zero and no strobe
    a_r10_held_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i) |-> (st_q.cnt == '0 && !st_q.stb));

    // R9: once at the top, the counter stays there until restarted
    a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == CNT_MAX && en_i && !restart_i) |=> st_q.cnt == CNT_MAX);

    // R7: every strobe coincides with a counter reloaded to one
    a_r7_reload_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.stb |-> st_q.cnt == CNT_ONE);

endmodule

// File: rtl/edge_interval_timer.sv
module edge_interval_timer
    import eit_pkg::*;
#(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_en_i,
    input  logic             line_i,
    input  logic [1:0]       edge_mode_i,
    input  logic [1:0]       win_mode_i,
    input  logic [CNT_W-1:0] nominal_i,
    output logic [CNT_W-1:0] interval_o,
    output logic             in_window_o,
    output logic             edge_stb_o
);
    localparam int unsigned MAX_SPAN = WIN_BASE + 1;

    logic             line_sync;
    logic             restart;
    logic             win_hit;
    logic [CNT_W-1:0] count;

    eit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (line_i),
        .sync_o  (line_sync)
    );

    eit_edge_pick u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (rx_en_i),
        .level_i   (line_sync),
        .mode_i    (edge_sel_e'(edge_mode_i)),
        .restart_o (restart)
    );

    eit_window #(.CNT_W(CNT_W)) u_window (
        .count_i   (count),
        .nominal_i (nominal_i),
        .mode_i    (win_mode_i),
        .hit_o     (win_hit)
    );

    eit_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (rx_en_i),
        .restart_i   (restart),
        .win_hit_i   (win_hit),
        .count_o     (count),
        .interval_o  (interval_o),
        .in_window_o (in_window_o),
        .stb_o       (edge_stb_o)
    );

    // R3: polarity off in the previous cycle means no strobe now
    a_r3_off_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(edge_mode_i == 2'b00) |-> !edge_stb_o);

    // R8: a captured hit never lies beyond the widest window
    a_r8_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_stb_o && in_window_o) |->
        (({1'b0, interval_o} + (CNT_W+1)'(MAX_SPAN) >= {1'b0, $past(nominal_i)}) &&
         ({1'b0, interval_o} <= {1'b0, $past(nominal_i)} + (CNT_W+1)'(MAX_SPAN))));

endmodule

// File: tb/edge_interval_timer_tb.sv
module edge_interval_timer_tb;
    localparam int W    = 12;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0, rst_n = 1'b0, en = 1'b0, line = 1'b0;
    logic [1:0]   emode = 2'b00, wmode = 2'b00;
    logic [W-1:0] nom = W'(20);
    logic [W-1:0] iv_o;
    logic         win_o, stb_o;

    edge_interval_timer #(.CNT_W(W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .rx_en_i(en), .line_i(line),
        .edge_mode_i(emode), .win_mode_i(wmode), .nominal_i(nom),
        .interval_o(iv_o), .in_window_o(win_o), .edge_stb_o(stb_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit run = 0;
    int stb_seen = 0, last_iv = 0, last_win = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_iv, m_win, m_stb;
    bit hist[$];
    bit s_new, s_old, m_rs;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_iv = 0; m_win = 0; m_stb = 0;
            hist = '{0, 0, 0};
        end else begin
            s_new = hist[1];
            s_old = hist[2];
            case (emode)
                2'b01:   m_rs = !s_new && s_old;
                2'b10:   m_rs = s_new && !s_old;
                2'b11:   m_rs = s_new != s_old;
                default: m_rs = 0;
            endcase
            if (!en) begin
                m_cnt = 0; m_stb = 0;
            end else if (m_rs) begin
                m_iv  = m_cnt;
                m_win = (m_cnt >= int'(nom) - (3 + int'(wmode[0])) &&
                         m_cnt <= int'(nom) + 3 + int'(wmode[1])) ? 1 : 0;
                m_cnt = 1; m_stb = 1;
            end else begin
                m_stb = 0;
                if (m_cnt < MAXV) m_cnt++;
            end
            hist.push_front(line);
            void'(hist.pop_back());
        end
    end

    // per-cycle comparison and strobe monitor
    string stag;
    always @(negedge clk) begin
        if (run) begin
            if (!en) stag = "R10";
            else case (emode)
                2'b00: stag = "R3";
                2'b01: stag = "R4";
                2'b10: stag = "R5";
                default: stag = "R6";
            endcase
            chk({stag, " strobe vs model"}, int'(stb_o), m_stb);
            chk("R7 interval vs model", int'(iv_o), m_iv);
            chk("R8 window vs model", int'(win_o), m_win);
            if (stb_o) begin
                stb_seen++;
                last_iv  = int'(iv_o);
                last_win = int'(win_o);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic train(int hi, int lo, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line = 1'b1;
            cyc(hi - 1);
            @(negedge clk) line = 1'b0;
            cyc(lo - 1);
        end
        cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(4);
        // R1 reset values
        chk("R1 interval at reset", int'(iv_o), 0);
        chk("R1 window at reset", int'(win_o), 0);
        chk("R1 strobe at reset", int'(stb_o), 0);
        @(negedge clk) rst_n = 1'b1;
        run = 1;
        cyc(2);
        chk("R1 strobe after reset", int'(stb_o), 0);

        // R2 latency
        en = 1'b1; emode = 2'b10;
        cyc(10);
        @(negedge clk) line = 1'b1;
        @(negedge clk) chk("R2 no strobe after 1 edge", int'(stb_o), 0);
        @(negedge clk) chk("R2 no strobe after 2 edges", int'(stb_o), 0);
        @(negedge clk) chk("R2 strobe after 3 edges", int'(stb_o), 1);
        cyc(5);
        @(negedge clk) line = 1'b0;
        cyc(10);

        // R5 rising only
        stb_seen = 0;
        train(6, 14, 4);
        chk("R5 rising strobe count", stb_seen, 4);
        chk("R5 interval", last_iv, 20);
        chk("R8 nominal in window", last_win, 1);

        // R4 falling only
        emode = 2'b01; cyc(4); stb_seen = 0;
        train(6, 14, 4);
        chk("R4 falling strobe count", stb_seen, 4);
        chk("R4 interval", last_iv, 20);

        // R6 both
        emode = 2'b11; cyc(4); stb_seen = 0;
        train(6, 14, 4);
        chk("R6 both strobe count", stb_seen, 8);
        chk("R6 last interval high time", last_iv, 6);

        // R3 off
        emode = 2'b00; cyc(4); stb_seen = 0;
        train(6, 14, 4);
        chk("R3 no strobes when off", stb_seen, 0);
        chk("R3 interval held", int'(iv_o), 6);

        // R8 window boundaries, nominal 20
        emode = 2'b10;
        for (int wm = 0; wm < 4; wm++) begin
            wmode = 2'(wm);
            for (int sp = 15; sp <= 25; sp++) begin
                train(5, sp - 5, 2);
                chk("R8 boundary interval", last_iv, sp);
                chk("R8 boundary flag", last_win,
                    (sp >= 20 - (3 + (wm & 1)) && sp <= 20 + 3 + (wm >> 1)) ? 1 : 0);
            end
        end
        wmode = 2'b00;

        // R9 saturation
        emode = 2'b00;
        cyc(MAXV + 200);
        emode = 2'b10;
        cyc(2);
        @(negedge clk) line = 1'b1;
        cyc(4);
        chk("R9 saturated interval", last_iv, MAXV);
        chk("R9 saturated out of window", last_win, 0);
        @(negedge clk) line = 1'b0;
        cyc(6);

        // R10 disabled
        en = 1'b0; stb_seen = 0;
        train(3, 5, 4);
        chk("R10 no strobes while disabled", stb_seen, 0);
        cyc(4);
        @(negedge clk) en = 1'b1;
        cyc(9);
        line = 1'b1;
        cyc(4);
        chk("R10 count restarted from zero", last_iv, 11);
        chk("R10 strobe after enable", stb_seen, 1);

        cyc(5);
        run = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule